// File: doc/BRIEF.md
# Accumulator ALU with Status Byte

This block is the arithmetic and logic stage of a small accumulator machine. The accumulator and one operand go in. A combinational result comes out in the same cycle. The unit can add, subtract, complement, do bitwise AND/OR/XOR, rotate one place either way, and shift one place either way arithmetically.

Each operation also produces Overflow, Negative, Zero and Carry. These four flags are loaded into a registered status byte on the clock edge when the flag write enable is high. The upper half of that byte samples four external sense switches on every edge, so software can test any switch or flag by a single-bit mask.

Top module: `acc_alu_top`

## Requirements
- R1: Operation code 0x0 adds: result = (acc + operand) mod 256, C = unsigned carry out, O = signed overflow.
- R2: Operation code 0x1 subtracts: result = (acc - operand) mod 256, C = 1 when no borrow occurs (acc >= operand unsigned), O = signed overflow.
- R3: Codes 0x2 NOT (complement of the operand), 0x3 AND, 0x4 OR and 0x5 XOR give the bitwise result, and they clear C and O.
- R4: Code 0x6 rotates acc left one place, with bit 7 wrapping into bit 0. Code 0x7 rotates right one place, with bit 0 wrapping into bit 7. C takes the wrapped bit, and O is cleared.
- R5: Code 0x8 shifts acc left and fills bit 0 with 0. C takes the old bit 7, and O is set when bit 7 changes value.
- R6: Code 0x9 shifts acc right and keeps bit 7. C takes the old bit 0, and O is cleared.
- R7: The flags sit in the status byte at O = bit 3 (0x08), N = bit 2 (0x04), Z = bit 1 (0x02) and C = bit 0 (0x01). On a clock edge with flag write high, N loads result bit 7 and Z loads (result == 0x00).
- R8: On an edge with flag write low, status bits 3..0 keep their value, while the result still follows the inputs.
- R9: On every clock edge, status bits 7..4 load sense inputs 3..0. Switch 1 is at bit 7 (0x80) and switch 4 at bit 4 (0x10). ALU results never change these bits.
- R10: An active-low asynchronous reset clears the whole status byte.
- R11: Codes 0xA to 0xF pass acc to the result unchanged and leave the flags untouched even when flag write is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| op_i | input | 4 | operation code |
| acc_i | input | 8 | accumulator value |
| opnd_i | input | 8 | operand value |
| flag_we_i | input | 1 | load flags on the next edge |
| sense_i | input | 4 | sense switches, bit 3 = switch 1 |
| result_o | output | 8 | combinational result |
| status_o | output | 8 | registered switches (7..4) and flags O N Z C (3..0) |

## Verification
The bench builds the block with its defaults: an 8-bit data path and four sense switches. With that width it can reach the signed and unsigned boundaries exactly: 0x7F/0x80 overflow, 0xFF+1 wrap, equal-operand subtraction, and bit 7 changing on a left shift. Fixed mask positions are checked by comparing the whole status byte rather than separate flags.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_SUB = 4'h1,
    OP_NOT = 4'h2,
    OP_AND = 4'h3,
    OP_OR  = 4'h4,
    OP_XOR = 4'h5,
    OP_ROL = 4'h6,
    OP_ROR = 4'h7,
    OP_ASL = 4'h8,
    OP_ASR = 4'h9
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic neg;
    logic zero;
    logic carry;
  } alu_flags_t;

  localparam int unsigned FLAG_W = $bits(alu_flags_t);
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  // subtract as a + ~b + 1; carry out then means "no borrow"
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o   = full[DATA_W-1:0];
  assign carry_o = full[DATA_W];
  assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              left_i,
  input  logic              ring_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    if (left_i) begin
      res_o   = {a_i[MSB-1:0], ring_i ? a_i[MSB] : 1'b0};
      carry_o = a_i[MSB];
      ovf_o   = ring_i ? 1'b0 : (a_i[MSB] ^ a_i[MSB-1]);
    end else begin
      res_o   = {ring_i ? a_i[0] : a_i[MSB], a_i[MSB:1]};
      carry_o = a_i[0];
      ovf_o   = 1'b0;
    end
  end

  always_comb begin
    if (ring_i) begin
      a_r4_ring_keeps_ones: assert ($countones(res_o) == $countones(a_i));
    end
    if (!ring_i && !left_i) begin
      a_r6_asr_keeps_sign: assert (res_o[MSB] == a_i[MSB]);
    end
  end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
  import acc_alu_pkg::*;
#(
  parameter int unsigned SENSE_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  alu_flags_t                flags_i,
  input  logic [SENSE_W-1:0]        sense_i,
  output logic [SENSE_W+FLAG_W-1:0] status_o
);
  localparam int unsigned ST_W = SENSE_W + FLAG_W;

  logic [SENSE_W-1:0] sense_q;
  alu_flags_t         flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sense_q <= '0;
    else         sense_q <= sense_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q <= flags_i;
  end

  assign status_o = {sense_q, flags_q};

  a_r9_sense_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[ST_W-1:FLAG_W] == $past(sense_i));

  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(status_o[FLAG_W-1:0]));
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SENSE_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [3:0]                op_i,
  input  logic [DATA_W-1:0]         acc_i,
  input  logic [DATA_W-1:0]         opnd_i,
  input  logic                      flag_we_i,
  input  logic [SENSE_W-1:0]        sense_i,
  output logic [DATA_W-1:0]         result_o,
  output logic [SENSE_W+FLAG_W-1:0] status_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] arith_res, shift_res;
  logic              arith_c, arith_o, shift_c, shift_o;
  logic              op_valid, we_eff;
  alu_flags_t        flags_d;

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .sub_i  (op_i == OP_SUB),
    .sum_o  (arith_res),
    .carry_o(arith_c),
    .ovf_o  (arith_o)
  );

  acc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i    (acc_i),
    .left_i (op_i == OP_ROL || op_i == OP_ASL),
    .ring_i (op_i == OP_ROL || op_i == OP_ROR),
    .res_o  (shift_res),
    .carry_o(shift_c),
    .ovf_o  (shift_o)
  );

  always_comb begin
    result_o      = acc_i;
    flags_d.carry = 1'b0;
    flags_d.ovf   = 1'b0;
    op_valid      = 1'b1;
    case (op_i)
      OP_ADD, OP_SUB: begin
        result_o      = arith_res;
        flags_d.carry = arith_c;
        flags_d.ovf   = arith_o;
      end
      OP_NOT: result_o = ~opnd_i;
      OP_AND: result_o = acc_i & opnd_i;
      OP_OR:  result_o = acc_i | opnd_i;
      OP_XOR: result_o = acc_i ^ opnd_i;
      OP_ROL, OP_ROR, OP_ASL, OP_ASR: begin
        result_o      = shift_res;
        flags_d.carry = shift_c;
        flags_d.ovf   = shift_o;
      end
      default: op_valid = 1'b0;
    endcase
    flags_d.neg  = result_o[MSB];
    flags_d.zero = ~|result_o;
  end

  assign we_eff = flag_we_i & op_valid;

  acc_alu_status #(.SENSE_W(SENSE_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_eff),
    .flags_i (flags_d),
    .sense_i (sense_i),
    .status_o(status_o)
  );

  a_r7_nz_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_eff |=> (status_o[2] == $past(result_o[MSB])) &&
               (status_o[1] == ($past(result_o) == '0)));

  a_r11_bad_op_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'h9) |=> $stable(status_o[FLAG_W-1:0]));
endmodule

// File: tb/acc_alu_top_bench.sv
module acc_alu_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       flag_we_i = 1'b0;
  logic [3:0] sense_i = '0;
  logic [7:0] result_o, status_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  acc_alu_top u_acc_alu_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .flag_we_i(flag_we_i), .sense_i(sense_i),
    .result_o(result_o), .status_o(status_o)
  );

  // {op, acc, opnd, result, flags O N Z C}
  localparam logic [31:0] VEC [17] = '{
    {4'h0, 8'h7F, 8'h01, 8'h80, 4'hC},  // R1 signed overflow
    {4'h0, 8'hFF, 8'h01, 8'h00, 4'h3},  // R1 carry wrap
    {4'h0, 8'h80, 8'h80, 8'h00, 4'hB},  // R1 both
    {4'h1, 8'h05, 8'h03, 8'h02, 4'h1},  // R2 no borrow
    {4'h1, 8'h03, 8'h05, 8'hFE, 4'h4},  // R2 borrow
    {4'h1, 8'h80, 8'h01, 8'h7F, 4'h9},  // R2 overflow
    {4'h1, 8'h42, 8'h42, 8'h00, 4'h3},  // R2 equal
    {4'h2, 8'h55, 8'h0F, 8'hF0, 4'h4},  // R3 NOT
    {4'h3, 8'hF0, 8'h3C, 8'h30, 4'h0},  // R3 AND
    {4'h4, 8'h00, 8'h00, 8'h00, 4'h2},  // R3 OR
    {4'h5, 8'hAA, 8'h55, 8'hFF, 4'h4},  // R3 XOR
    {4'h6, 8'h81, 8'h00, 8'h03, 4'h1},  // R4 rotate left
    {4'h7, 8'h01, 8'h00, 8'h80, 4'h5},  // R4 rotate right
    {4'h8, 8'h40, 8'h00, 8'h80, 4'hC},  // R5 bit7 0->1
    {4'h8, 8'h80, 8'h00, 8'h00, 4'hB},  // R5 bit7 1->0
    {4'h9, 8'h81, 8'h00, 8'hC0, 4'h5},  // R6 sign kept
    {4'h9, 8'h02, 8'h00, 8'h01, 4'h0}   // R6 positive
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic string vreq(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3, 4'h4, 4'h5: return "R3";
      4'h6, 4'h7: return "R4";
      4'h8: return "R5";
      default: return "R6";
    endcase
  endfunction

  // drive after negedge, check result mid-low phase, flags after the edge
  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic we);
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; flag_we_i = we;
    #2;
  endtask

  initial begin
    sense_i = 4'hF;
    #25;
    chk("R10 reset", status_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sense_i = 4'hA;
    @(posedge clk_i); #5;
    chk("R9 switches 0xA", status_o, 8'hA0);

    for (int i = 0; i < 17; i++) begin
      apply(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12], 1'b1);
      chk({vreq(VEC[i][31:28]), " result"}, result_o, VEC[i][11:4]);
      @(posedge clk_i); #5;
      chk({vreq(VEC[i][31:28]), " R7 status"}, status_o, {4'hA, VEC[i][3:0]});
    end

    // R8: write disabled, flags keep last vector's 0x0
    apply(4'h0, 8'hFF, 8'h01, 1'b0);
    chk("R8 result live", result_o, 8'h00);
    @(posedge clk_i); #5;
    chk("R8 flags hold", status_o, 8'hA0);

    // load known flags 0x3, then unused code must keep them
    apply(4'h0, 8'hFF, 8'h01, 1'b1);
    @(posedge clk_i); #5;
    chk("R7 load", status_o, 8'hA3);
    apply(4'hC, 8'h5A, 8'hFF, 1'b1);
    chk("R11 passthrough", result_o, 8'h5A);
    @(posedge clk_i); #5;
    chk("R11 flags hold", status_o, 8'hA3);
    apply(4'hF, 8'h00, 8'h00, 1'b1);
    chk("R11 passthrough zero", result_o, 8'h00);
    @(posedge clk_i); #5;
    chk("R11 flags hold 0xF", status_o, 8'hA3);

    // R9: switches change independently of flag write, switch 1 -> bit 7
    @(negedge clk_i); sense_i = 4'h8; flag_we_i = 1'b0;
    @(posedge clk_i); #5;
    chk("R9 switch1 mask 0x80", status_o, 8'h83);
    @(negedge clk_i); sense_i = 4'h1;
    @(posedge clk_i); #5;
    chk("R9 switch4 mask 0x10", status_o, 8'h13);

    // R10: asynchronous reset mid-run
    @(negedge clk_i); #3 rst_ni = 1'b0; #1;
    chk("R10 async clear", status_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule